// File: doc/BRIEF.md
# Four-Mode Timer/Counter Pair

Two identical timer/counter units, each holding a 16-bit count split into a low and a high byte. A unit advances either on internal machine-cycle ticks (timer) or on falling edges of its own event pin (counter). A run bit and an optional gate pin control whether it advances. Each unit raises an overflow flag when its counting field wraps.

Each unit has a mode register whose value is the unit's state. There are four states: `MODE_13`, `MODE_16`, `MODE_8R` and `MODE_SPLIT`. After reset every unit is in `MODE_13`. A configuration write moves a unit straight to the state coded in its nibble, from any state to any state. No other event changes the state.

- In `MODE_13` the low byte's bottom `PRE_W` bits act as a prescaler whose carry feeds the high byte.
- In `MODE_16` the full 16-bit value counts.
- In `MODE_8R` the low byte counts and reloads from the high byte when it wraps.
- In `MODE_SPLIT` unit 0 becomes two independent 8-bit timers. Its high byte counts ticks under unit 1's run bit and drives unit 1's flag.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset both counts are 0, both flags are 0, and both units are in `MODE_13` as timers with gating off.
- R2: A timer unit advances by one on each cycle with `tick`=1 while its run bit is 1. It holds its count while the run bit is 0 or `tick` is 0.
- R3: A unit with the event select bit set samples its event pin on each `tick` cycle. It counts one when the previous sample was 1 and the current pin value is 0. Pin changes between ticks, a steady pin and rising edges do not count.
- R4: In `MODE_13` (mode code 00), low bits [4:0] form a prescaler whose carry increments the high byte. Low bits [7:5] never change by counting. Going from 0x1FFF in the 13-bit field to 0 sets the flag.
- R5: In `MODE_16` (mode code 01), the count wraps from 0xFFFF to 0x0000 and sets the flag.
- R6: In `MODE_8R` (mode code 10), only the low byte counts. On 0xFF it loads the high byte's value and sets the flag. The high byte is unchanged.
- R7: With unit 0 in `MODE_SPLIT` (mode code 11):
  - Unit 0's low byte counts under unit 0's own controls and its wrap sets flag 0.
  - Unit 0's high byte counts ticks while `run[1]`=1 and its wrap sets flag 1.
- R8: While unit 0 is in `MODE_SPLIT`, unit 1 keeps counting in its own mode but its own wrap does not set flag 1. Unit 1 placed in `MODE_SPLIT` holds its count.
- R9: A flag is set on the same clock edge at which its counting field wraps. `ovf_clr` clears a flag, but a set on that same edge wins.
- R10: A byte load on `ld_lo`/`ld_hi` takes priority over counting of that byte in the same cycle.
- R11: With the gate bit (nibble bit 3) set, a unit advances only while both its run bit and its gate pin are 1.

The configuration word holds unit 0 in bits [3:0] and unit 1 in bits [7:4]. Within each nibble:
- bits [1:0] are the mode code;
- bit 2 selects the event pin;
- bit 3 enables gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle enable: timer increment and event sample strobe |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_data | input | 8 | Configuration word, one nibble per unit |
| run | input | 2 | Run bit per unit |
| gate_pin | input | 2 | External gate pin per unit |
| ev_pin | input | 2 | External event pin per unit |
| ld_lo | input | 2 | Load low byte of a unit from `ld_data` |
| ld_hi | input | 2 | Load high byte of a unit from `ld_data` |
| ld_data | input | 8 | Byte value for loads |
| ovf_clr | input | 2 | Clear overflow flag per unit |
| count0 | output | 16 | Unit 0 count {high, low} |
| count1 | output | 16 | Unit 1 count {high, low} |
| ovf | output | 2 | Overflow flag per unit |

## Verification
The bench builds the block with `BYTE_W`=8 and `PRE_W`=5. With these values the 13-bit field wraps after 8192 increments and each byte wraps after 256. Byte loads therefore place every wrap boundary (13-bit, 16-bit, 8-bit reload and both halves of the split) within a few cycles of a check. The small prescaler width also lets the default `MODE_13` carry into the high byte be seen after only 32 ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CFG_W = 4;

    typedef enum logic [1:0] {
        MODE_13    = 2'b00,
        MODE_16    = 2'b01,
        MODE_8R    = 2'b10,
        MODE_SPLIT = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ext_sel;
        tmr_mode_e mode;
    } tmr_cfg_t;
endpackage

// File: rtl/ev_sampler.sv
module ev_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic smp_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            smp_q <= 1'b0;
        else if (tick)
            smp_q <= pin;
    end

    // event: previous sample high, current sample low
    assign fall = tick & smp_q & ~pin;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int PRE_W       = 5,
    parameter bit ALLOW_SPLIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  tmr_cfg_t          cfg_in,
    input  logic              tick,
    input  logic              ev_fall,
    input  logic              run,
    input  logic              gate_pin,
    input  logic              inc_hi,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [BYTE_W-1:0] ld_data,
    output tmr_mode_e         mode_o,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              wrap_main,
    output logic              wrap_hi
);
    localparam int T13_W = BYTE_W + PRE_W + 1;
    localparam int T16_W = 2 * BYTE_W + 1;

    tmr_mode_e         state_q, state_d;
    logic              gate_q, ext_q;
    logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
    logic [T13_W-1:0]  t13;
    logic [T16_W-1:0]  t16;
    logic              run_ok, inc_main;

    // state register: mode changes only on a configuration write
    always_comb begin
        state_d = cfg_wr ? cfg_in.mode : state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_13;
            gate_q  <= 1'b0;
            ext_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cfg_wr) begin
                gate_q <= cfg_in.gate;
                ext_q  <= cfg_in.ext_sel;
            end
        end
    end

    assign run_ok   = run & (~gate_q | gate_pin);
    assign inc_main = run_ok & (ext_q ? ev_fall : tick);

    // output process: next count and wrap strobes per state
    always_comb begin
        lo_n      = lo_q;
        hi_n      = hi_q;
        wrap_main = 1'b0;
        wrap_hi   = 1'b0;
        t13       = '0;
        t16       = '0;
        unique case (state_q)
            MODE_13: begin
                if (inc_main) begin
                    t13 = {1'b0, hi_q, lo_q[PRE_W-1:0]} + T13_W'(1);
                    lo_n[PRE_W-1:0] = t13[PRE_W-1:0];
                    hi_n            = t13[PRE_W +: BYTE_W];
                    wrap_main       = t13[T13_W-1];
                end
            end
            MODE_16: begin
                if (inc_main) begin
                    t16       = {1'b0, hi_q, lo_q} + T16_W'(1);
                    lo_n      = t16[BYTE_W-1:0];
                    hi_n      = t16[BYTE_W +: BYTE_W];
                    wrap_main = t16[T16_W-1];
                end
            end
            MODE_8R: begin
                if (inc_main) begin
                    if (&lo_q) begin
                        lo_n      = hi_q;
                        wrap_main = 1'b1;
                    end else begin
                        lo_n = lo_q + BYTE_W'(1);
                    end
                end
            end
            MODE_SPLIT: begin
                if (ALLOW_SPLIT) begin
                    if (inc_main) begin
                        lo_n      = lo_q + BYTE_W'(1);
                        wrap_main = &lo_q;
                    end
                    if (inc_hi) begin
                        hi_n    = hi_q + BYTE_W'(1);
                        wrap_hi = &hi_q;
                    end
                end
            end
        endcase
        if (ld_lo) lo_n = ld_data;
        if (ld_hi) hi_n = ld_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    assign mode_o = state_q;
    assign lo     = lo_q;
    assign hi     = hi_q;
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  cfg_wr,
    input  logic [2*CFG_W-1:0]    cfg_data,
    input  logic [1:0]            run,
    input  logic [1:0]            gate_pin,
    input  logic [1:0]            ev_pin,
    input  logic [1:0]            ld_lo,
    input  logic [1:0]            ld_hi,
    input  logic [BYTE_W-1:0]     ld_data,
    input  logic [1:0]            ovf_clr,
    output logic [2*BYTE_W-1:0]   count0,
    output logic [2*BYTE_W-1:0]   count1,
    output logic [1:0]            ovf
);
    localparam int NUM_U = 2;

    logic [BYTE_W-1:0] lo_a [NUM_U];
    logic [BYTE_W-1:0] hi_a [NUM_U];
    tmr_mode_e         mode_a [NUM_U];
    logic [NUM_U-1:0]  wrap_main_a, wrap_hi_a, fall_a;
    logic [NUM_U-1:0]  ovf_q, ovf_set;
    tmr_mode_e         mode0_w, mode1_w;

    for (genvar u = 0; u < NUM_U; u++) begin : g_unit
        ev_sampler u_smp (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .pin   (ev_pin[u]),
            .fall  (fall_a[u])
        );

        tmr_unit #(
            .BYTE_W      (BYTE_W),
            .PRE_W       (PRE_W),
            .ALLOW_SPLIT (u == 0)
        ) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_wr    (cfg_wr),
            .cfg_in    (tmr_cfg_t'(cfg_data[u*CFG_W +: CFG_W])),
            .tick      (tick),
            .ev_fall   (fall_a[u]),
            .run       (run[u]),
            .gate_pin  (gate_pin[u]),
            .inc_hi    ((u == 0) ? (tick & run[1]) : 1'b0),
            .ld_lo     (ld_lo[u]),
            .ld_hi     (ld_hi[u]),
            .ld_data   (ld_data),
            .mode_o    (mode_a[u]),
            .lo        (lo_a[u]),
            .hi        (hi_a[u]),
            .wrap_main (wrap_main_a[u]),
            .wrap_hi   (wrap_hi_a[u])
        );
    end

    assign mode0_w = mode_a[0];
    assign mode1_w = mode_a[1];

    // unit 1's flag belongs to unit 0's high byte while unit 0 is split
    always_comb begin
        ovf_set[0] = wrap_main_a[0];
        ovf_set[1] = (mode0_w == MODE_SPLIT) ? (|wrap_hi_a) : wrap_main_a[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= '0;
        else
            ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
    end

    assign count0 = {hi_a[0], lo_a[0]};
    assign count1 = {hi_a[1], lo_a[1]};
    assign ovf    = ovf_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          run,
    input logic [1:0]          ld_lo,
    input logic [1:0]          ld_hi,
    input logic [1:0]          ovf_clr,
    input logic [2*BYTE_W-1:0] count0,
    input logic [2*BYTE_W-1:0] count1,
    input logic [1:0]          ovf,
    input tmr_mode_e           mode0,
    input tmr_mode_e           mode1
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 != MODE_SPLIT && !run[0] && !ld_lo[0] && !ld_hi[0]) |=> $stable(count0));

    assert_prescale_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode0) == MODE_13 && !$past(ld_lo[0])) |-> (count0[7:5] == $past(count0[7:5])));

    assert_wrap16_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode0) == MODE_16 && $rose(ovf[0]) && !$past(ld_lo[0]) && !$past(ld_hi[0]))
        |-> (count0 == '0));

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode0) == MODE_8R && $rose(ovf[0]) && !$past(ld_lo[0]))
        |-> (count0[BYTE_W-1:0] == $past(count0[2*BYTE_W-1:BYTE_W])));

    assert_split_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == MODE_SPLIT && !ld_lo[1] && !ld_hi[1]) |=> $stable(count1));

    assert_no_flag1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == MODE_SPLIT && !run[1] && !ovf[1]) |=> !ovf[1]);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf[0]) |-> $past(ovf_clr[0]));
endmodule

bind dual_mode_timer tmr_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .ld_lo   (ld_lo),
    .ld_hi   (ld_hi),
    .ovf_clr (ovf_clr),
    .count0  (count0),
    .count1  (count1),
    .ovf     (ovf),
    .mode0   (mode0_w),
    .mode1   (mode1_w)
);

// File: tb/dual_mode_timer_test.sv
module dual_mode_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_data = '0;
    logic [1:0]  run = '0;
    logic [1:0]  gate_pin = '0;
    logic [1:0]  ev_pin = '0;
    logic [1:0]  ld_lo = '0;
    logic [1:0]  ld_hi = '0;
    logic [7:0]  ld_data = '0;
    logic [1:0]  ovf_clr = '0;
    logic [15:0] count0, count1;
    logic [1:0]  ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dual_mode_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .run(run), .gate_pin(gate_pin), .ev_pin(ev_pin), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .ld_data(ld_data), .ovf_clr(ovf_clr), .count0(count0), .count1(count1), .ovf(ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic configure(input logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_data = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic load(input int u, input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk); ld_lo[u] = 1'b1; ld_data = lo;
        @(negedge clk); ld_lo[u] = 1'b0; ld_hi[u] = 1'b1; ld_data = hi;
        @(negedge clk); ld_hi[u] = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); ovf_clr = 2'b11;
        @(negedge clk); ovf_clr = 2'b00;
    endtask

    task automatic run_cycles(input logic [1:0] r, input int n);
        @(negedge clk); run = r; tick = 1'b1;
        repeat (n) @(negedge clk);
        run = 2'b00; tick = 1'b0;
    endtask

    task automatic evt(input logic p);
        @(negedge clk); ev_pin[0] = p; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic t_reset_R1();
        chk("R1 count0 after reset", count0, 32'h0);
        chk("R1 count1 after reset", count1, 32'h0);
        chk("R1 flags after reset", ovf, 32'h0);
        run_cycles(2'b01, 32);
        chk("R1 default 13-bit carry after 32 ticks", count0, 32'h0100);
    endtask

    task automatic t_timer_R2();
        configure(8'h11);
        load(0, 8'h00, 8'h00);
        run_cycles(2'b01, 10);
        chk("R2 ten ticks counted", count0, 32'd10);
        run_cycles(2'b00, 5);
        chk("R2 hold with run low", count0, 32'd10);
        @(negedge clk); run = 2'b01; tick = 1'b0;
        repeat (4) @(negedge clk);
        run = 2'b00;
        chk("R2 hold with tick low", count0, 32'd10);
    endtask

    task automatic t_gate_R11();
        configure(8'h19);
        load(0, 8'h00, 8'h00);
        gate_pin = 2'b00;
        run_cycles(2'b01, 5);
        chk("R11 gate pin low blocks", count0, 32'd0);
        gate_pin = 2'b01;
        run_cycles(2'b01, 5);
        chk("R11 gate pin high counts", count0, 32'd5);
        run_cycles(2'b00, 5);
        chk("R11 run low blocks", count0, 32'd5);
        gate_pin = 2'b00;
    endtask

    task automatic t_event_R3();
        configure(8'h15);
        load(0, 8'h00, 8'h00);
        @(negedge clk); run = 2'b01;
        evt(1); evt(0); evt(0); evt(1); evt(0); evt(1); evt(1); evt(0);
        chk("R3 three falling edges", count0, 32'd3);
        evt(1);
        @(negedge clk); ev_pin[0] = 1'b0;
        @(negedge clk); ev_pin[0] = 1'b1;
        evt(1);
        run = 2'b00;
        chk("R3 pulse between ticks ignored", count0, 32'd3);
        ev_pin[0] = 1'b0;
    endtask

    task automatic t_m13_R4();
        configure(8'h10);
        load(0, 8'hFE, 8'hFF);
        clear_flags();
        run_cycles(2'b01, 1);
        chk("R4 13-bit at top", count0, 32'hFFFF);
        chk("R4 no early flag", ovf[0], 32'd0);
        run_cycles(2'b01, 1);
        chk("R4 13-bit wrap keeps low[7:5]", count0, 32'h00E0);
        chk("R4 13-bit wrap flag", ovf[0], 32'd1);
    endtask

    task automatic t_m16_R5();
        configure(8'h11);
        load(0, 8'hFE, 8'hFF);
        clear_flags();
        run_cycles(2'b01, 1);
        chk("R5 16-bit at top", count0, 32'hFFFF);
        chk("R9 flag not before wrap", ovf[0], 32'd0);
        run_cycles(2'b01, 1);
        chk("R5 16-bit wrap", count0, 32'h0000);
        chk("R9 flag with wrap", ovf[0], 32'd1);
        @(negedge clk); ovf_clr = 2'b01;
        @(negedge clk); ovf_clr = 2'b00;
        chk("R9 clear", ovf[0], 32'd0);
        load(0, 8'hFF, 8'hFF);
        @(negedge clk); run = 2'b01; tick = 1'b1; ovf_clr = 2'b01;
        @(negedge clk); run = 2'b00; tick = 1'b0; ovf_clr = 2'b00;
        chk("R9 set wins over clear", ovf[0], 32'd1);
    endtask

    task automatic t_m8r_R6();
        configure(8'h21);
        load(1, 8'hFD, 8'h80);
        clear_flags();
        run_cycles(2'b10, 2);
        chk("R6 before reload", count1, 32'h80FF);
        chk("R6 no flag before reload", ovf[1], 32'd0);
        run_cycles(2'b10, 1);
        chk("R6 reload from high", count1, 32'h8080);
        chk("R6 reload flag", ovf[1], 32'd1);
        run_cycles(2'b10, 2);
        chk("R6 count after reload", count1, 32'h8082);
    endtask

    task automatic t_split_R7_R8();
        configure(8'h13);
        load(0, 8'hFE, 8'hFD);
        load(1, 8'h00, 8'h00);
        clear_flags();
        run_cycles(2'b01, 2);
        chk("R7 split low wraps, high held", count0, 32'hFD00);
        chk("R7 split low flag", ovf, 32'b01);
        clear_flags();
        run_cycles(2'b10, 3);
        chk("R7 split high wraps", count0, 32'h0000);
        chk("R7 split high sets flag1", ovf, 32'b10);
        chk("R8 unit1 still counts", count1, 32'd3);
        load(1, 8'hFF, 8'hFF);
        clear_flags();
        run_cycles(2'b10, 1);
        chk("R8 unit1 wrapped", count1, 32'h0000);
        chk("R8 unit1 wrap gives no flag1", ovf[1], 32'd0);
        configure(8'h31);
        load(1, 8'h34, 8'h12);
        run_cycles(2'b10, 5);
        chk("R8 unit1 split holds", count1, 32'h1234);
    endtask

    task automatic t_load_R10();
        configure(8'h11);
        load(0, 8'h10, 8'h00);
        @(negedge clk); run = 2'b01; tick = 1'b1; ld_lo[0] = 1'b1; ld_data = 8'h55;
        @(negedge clk); run = 2'b00; tick = 1'b0; ld_lo[0] = 1'b0;
        chk("R10 low load beats count", count0, 32'h0055);
        @(negedge clk); run = 2'b01; tick = 1'b1; ld_hi[0] = 1'b1; ld_data = 8'h7A;
        @(negedge clk); run = 2'b00; tick = 1'b0; ld_hi[0] = 1'b0;
        chk("R10 high load beats count", count0, 32'h7A56);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_timer_R2();
        t_gate_R11();
        t_event_R3();
        t_m13_R4();
        t_m16_R5();
        t_m8r_R6();
        t_split_R7_R8();
        t_load_R10();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule